// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block produces the bus timing for a processor whose low address byte and data byte use the same 8 pins. When a cycle request arrives, the block starts a machine cycle. In the first clock it drives the full 16-bit address: the upper byte goes on dedicated lines, and the low byte goes on the shared lines while an address latch enable strobe is high. An external latch captures the low byte on that strobe, and the block also presents the rebuilt address on its own output.

From the second clock onward the shared lines carry write data or are released for the external device to drive. An active-low read or write strobe stays asserted until the final clock of the cycle. A ready input lengthens the cycle with wait clocks. Read data is captured as the read strobe ends. One turnaround clock then keeps the block's drivers off before any new cycle can start.

Opcode fetches take their address from an internal program counter, which steps by one after each fetch. A branch-fetch request fetches from the requested address and reloads the counter from it. Instruction decoding and arithmetic are outside this block.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset, `ale` is 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0, `busy` is 0, `rdata_valid` is 0 and `rdata` is 0. This state holds until the first request is accepted.
- R2: A request is accepted at a clock edge where `busy` is 0 and `req_valid` is 1. In the clock that follows, the block is in the address clock: `ale` is 1 for exactly that one clock, `ad_oe` is 1, `ad_out` equals address bits [7:0], and `rd_n` and `wr_n` are both 1.
- R3: `addr_hi` equals address bits [15:8] from the address clock through the last clock of the cycle, and keeps that value until the next cycle's address clock.
- R4: For a fetch (`req_kind`=2'b00), a read (2'b01) or a branch-fetch (2'b11), `ad_oe` is 0 from the second clock onward. `rd_n` is 0 from the second clock through the final clock, and `wr_n` stays 1.
- R5: For a write (2'b10), `ad_oe` is 1 and `ad_out` equals the write data from the second clock through the final clock. `wr_n` is 0 over the same clocks and `rd_n` stays 1. The clock after the final clock is idle.
- R6: `ready` is sampled at the end of the second clock and at the end of each wait clock. Each low sample inserts one wait clock in which the strobe, the drivers and the address do not change. A cycle with N low samples therefore has its strobe low for 2+N clocks.
- R7: For read-type cycles, `rdata` takes the value of `ad_in` at the edge that ends the final strobe clock. `rdata_valid` is 1 for exactly the one following clock.
- R8: After a read-type cycle there is one turnaround clock. In that clock `rd_n`, `wr_n` and `ale` are inactive, `ad_oe` is 0 and `busy` is 1. The block never drives `ad_oe` while `rd_n` is 0.
- R9: The program counter resets to 0x0000. A fetch uses the counter value as its address and then increments the counter by one, wrapping from 0xFFFF to 0x0000.
- R10: A branch-fetch uses `req_addr` as its address and sets the counter to `req_addr`+1.
- R11: `lat_addr` equals {`addr_hi`, the low byte driven during the address clock} from the clock after the address clock until the next address clock.
- R12: A `req_valid` pulse while `busy` is 1 is ignored and starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Cycle request, accepted when not busy |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 branch-fetch |
| req_addr | input | 16 | Address for read, write and branch-fetch |
| req_wdata | input | 8 | Write data |
| ready | input | 1 | Device ready; low inserts wait clocks |
| ad_in | input | 8 | Value seen on the shared pins |
| ad_out | output | 8 | Value driven on the shared pins |
| ad_oe | output | 1 | Output enable for the shared pins |
| addr_hi | output | 8 | Dedicated upper address lines |
| ale | output | 1 | Address latch enable strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | A cycle or turnaround is in progress |
| lat_addr | output | 16 | Demultiplexed full address |
| rdata | output | 8 | Captured read data |
| rdata_valid | output | 1 | One-clock pulse after a read capture |

## Verification
The bench runs sequences of plain fetches, then a branch-fetch followed by fetches. This shows whether the counter or `req_addr` supplies the address, and includes a branch to 0xFFFF to cover the counter wrap. Reads and writes run with zero, two and three wait clocks, which separates the fixed two-clock strobe from the ready-driven lengthening. A read followed at once by a write confirms that the turnaround clock keeps the drivers off. A request pulsed in the middle of a cycle must leave the count of latch strobes unchanged. On every clock the outputs are compared against a behavioural model that changing `ad_in` feeds, so a stale or early data capture shows up.

// File: rtl/mbs_pkg.sv
// Shared types for the multiplexed bus sequencer.
package mbs_pkg;
    typedef enum logic [1:0] {
        K_FETCH = 2'b00,
        K_READ  = 2'b01,
        K_WRITE = 2'b10,
        K_JUMP  = 2'b11
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_STRB,
        S_WAIT,
        S_LAST,
        S_TURN
    } phase_e;
endpackage

// File: rtl/mbs_phase_fsm.sv
// Phase sequencer: steps one machine cycle through its address clock, its
// strobe clocks (including ready-driven waits) and an optional turnaround.
// Assumes cur_write is stable from the clock after acceptance to cycle end.
module mbs_phase_fsm
    import mbs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   ready,
    input  logic   cur_write,
    output phase_e phase,
    output logic   accept
);
    phase_e phase_nx;

    // A request is taken only between cycles.
    assign accept = (phase == S_IDLE) && req_valid;

    // Next-phase selection.
    always_comb begin
        phase_nx = phase;
        case (phase)
            S_IDLE:         if (req_valid) phase_nx = S_ADDR;
            S_ADDR:         phase_nx = S_STRB;
            S_STRB, S_WAIT: phase_nx = ready ? S_LAST : S_WAIT;
            S_LAST:         phase_nx = cur_write ? S_IDLE : S_TURN;
            S_TURN:         phase_nx = S_IDLE;
            default:        phase_nx = S_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= S_IDLE;
        else        phase <= phase_nx;
    end

    // R2: the address clock lasts exactly one clock.
    p_addr_one_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == S_ADDR) |=> (phase == S_STRB));
    // R6: a low ready in a strobe clock yields a wait clock.
    p_wait_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == S_STRB || phase == S_WAIT) && !ready) |=> (phase == S_WAIT));
    // R8: a read-type cycle always ends in a turnaround clock.
    p_turn_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == S_LAST && !cur_write) |=> (phase == S_TURN));
endmodule

// File: rtl/mbs_addr_path.sv
// Address and data path: holds the current cycle's address, kind and write
// data, keeps the fetch counter, and captures read data as the strobe ends.
// Assumes accept is high only in the idle phase.
module mbs_addr_path
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_e            phase,
    input  logic [DATA_W-1:0] ad_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              cur_write,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    kind_e             kind;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] addr_sel;

    assign kind     = kind_e'(req_kind);
    assign addr_sel = (kind == K_FETCH) ? pc : req_addr;

    // Latch the request fields when a cycle is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_write <= 1'b0;
        end else if (accept) begin
            cur_addr  <= addr_sel;
            cur_wdata <= req_wdata;
            cur_write <= (kind == K_WRITE);
        end
    end

    // Fetch counter: steps after a fetch, reloads on a branch-fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (accept) begin
            if (kind == K_FETCH)     pc <= pc + ONE;
            else if (kind == K_JUMP) pc <= req_addr + ONE;
        end
    end

    // Capture read data on the edge that ends the final strobe clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= (phase == S_LAST) && !cur_write;
            if ((phase == S_LAST) && !cur_write) rdata <= ad_in;
        end
    end

    // R9: a fetch advances the counter by one.
    p_pc_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == K_FETCH) |=> (pc == $past(pc) + ONE));
    // R7: the valid flag is a single-clock pulse.
    p_rvalid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid);
endmodule

// File: rtl/mbs_lo_latch.sv
// Model of the companion address latch: follows the shared pins while the
// strobe is high and holds the last value once it falls.
module mbs_lo_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [DATA_W-1:0] pins,
    output logic [DATA_W-1:0] lo
);
    // Capture the low address byte while the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n)   lo <= '0;
        else if (ale) lo <= pins;
    end

    // R11: the held byte changes only on a strobe clock.
    p_lat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> $stable(lo));
endmodule

// File: rtl/mux_bus_seq.sv
// Top of the multiplexed address/data bus sequencer. It decodes the phase
// into pin strobes and driver enables and rebuilds the full address.
// Assumes the external device drives ad_in only while rd_n is low.
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              busy,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);
    localparam int HI_W = ADDR_W - DATA_W;

    phase_e            phase;
    logic              accept;
    logic              cur_write;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic [DATA_W-1:0] lat_lo;
    logic              in_strobe;

    mbs_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ready     (ready),
        .cur_write (cur_write),
        .phase     (phase),
        .accept    (accept)
    );

    mbs_addr_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_kind    (req_kind),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .phase       (phase),
        .ad_in       (ad_in),
        .cur_addr    (cur_addr),
        .cur_wdata   (cur_wdata),
        .cur_write   (cur_write),
        .rdata       (rdata),
        .rdata_valid (rdata_valid)
    );

    mbs_lo_latch #(.DATA_W(DATA_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .ale   (ale),
        .pins  (ad_out),
        .lo    (lat_lo)
    );

    // Decode the phase into strobes, enables and pin values.
    always_comb begin
        in_strobe = (phase == S_STRB) || (phase == S_WAIT) || (phase == S_LAST);
        ale       = (phase == S_ADDR);
        rd_n      = !(in_strobe && !cur_write);
        wr_n      = !(in_strobe && cur_write);
        ad_oe     = ale || (in_strobe && cur_write);
        ad_out    = ale ? cur_addr[DATA_W-1:0] : cur_wdata;
        busy      = (phase != S_IDLE);
    end

    assign addr_hi  = cur_addr[ADDR_W-1:DATA_W];
    assign lat_addr = {addr_hi, lat_lo};

    // R2: no data strobe during the address clock.
    p_ale_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && ad_oe));
    // R3: upper lines stay put outside the address clock.
    p_hi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |-> $stable(addr_hi));
    // R8: never drive the pins while the device may drive them.
    p_no_contend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    // R8: the clock after a read strobe ends keeps the drivers off.
    p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> (!ad_oe && busy));
    // R4: the two strobes are never active together.
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || wr_n));
    // R6: a wait clock leaves the strobes and drivers unchanged.
    p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == S_WAIT) |-> ($stable(rd_n) && $stable(wr_n) && $stable(ad_oe)));
endmodule

// File: tb/mux_bus_seq_tb.sv
module mux_bus_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        ready = 1'b1;
    logic [7:0]  ad_in = 8'h17;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  addr_hi;
    logic        ale, rd_n, wr_n, busy, rdata_valid;
    logic [15:0] lat_addr;
    logic [7:0]  rdata;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int wreq = 0;
    int wseen = 0;
    int ale_cnt = 0;
    int issued = 0;
    bit started = 0;

    // Behavioural reference state.
    int          m_clk = 0;
    bit          m_final = 0, m_tt = 0, m_wr = 0, m_rv = 0;
    logic [15:0] m_addr = 0, m_pc = 0;
    logic [7:0]  m_wd = 0, m_rd = 0, m_lat = 0;

    always #10 clk = ~clk;

    mux_bus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .busy(busy), .lat_addr(lat_addr), .rdata(rdata),
        .rdata_valid(rdata_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, advanced on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        started = 1;
        m_rv = 0;
        if (!rst_n) begin
            m_clk = 0; m_final = 0; m_tt = 0; m_wr = 0;
            m_addr = 0; m_pc = 0; m_wd = 0; m_rd = 0; m_lat = 0;
        end else begin
            if (m_clk == 1) m_lat = m_addr[7:0];
            if (m_tt) m_tt = 0;
            else if (m_clk == 0) begin
                if (req_valid) begin
                    m_wr = (req_kind == 2'b10);
                    m_wd = req_wdata;
                    if (req_kind == 2'b00) begin m_addr = m_pc; m_pc = m_pc + 1; end
                    else if (req_kind == 2'b11) begin m_addr = req_addr; m_pc = req_addr + 1; end
                    else m_addr = req_addr;
                    m_clk = 1; m_final = 0;
                end
            end else if (m_clk == 1) m_clk = 2;
            else if (!m_final) begin
                if (ready) m_final = 1;
                m_clk++;
            end else begin
                if (!m_wr) begin m_rd = ad_in; m_rv = 1; m_tt = 1; end
                m_clk = 0;
            end
        end
    end

    // Clock-by-clock comparison away from the rising edge.
    always @(negedge clk) begin
        if (started) begin
            bit e_ale, e_str, e_oe, e_busy;
            e_ale  = (m_clk == 1);
            e_str  = (m_clk >= 2);
            e_oe   = e_ale || (e_str && m_wr);
            e_busy = (m_clk != 0) || m_tt;
            if (!rst_n) begin
                chk(!ale && rd_n && wr_n && !ad_oe && !busy && !rdata_valid && rdata == 0,
                    "R1 reset state", {ale, rd_n, wr_n, ad_oe, busy}, 5'b01100);
            end else begin
                if (ale) ale_cnt++;
                chk(ale == e_ale, "R2 ale", ale, e_ale);
                chk(rd_n == !(e_str && !m_wr), "R4 rd_n", rd_n, !(e_str && !m_wr));
                chk(wr_n == !(e_str && m_wr), "R5 wr_n", wr_n, !(e_str && m_wr));
                chk(ad_oe == e_oe, "R8 ad_oe", ad_oe, e_oe);
                chk(busy == e_busy, "R8 busy", busy, e_busy);
                if (e_oe)
                    chk(ad_out == (e_ale ? m_addr[7:0] : m_wd), "R5 ad_out",
                        ad_out, e_ale ? m_addr[7:0] : m_wd);
                chk(addr_hi == m_addr[15:8], "R3 addr_hi", addr_hi, m_addr[15:8]);
                chk(rdata == m_rd, "R7 rdata", rdata, m_rd);
                chk(rdata_valid == m_rv, "R7 rdata_valid", rdata_valid, m_rv);
                chk(lat_addr == {m_addr[15:8], m_lat}, "R11 lat_addr",
                    lat_addr, {m_addr[15:8], m_lat});
            end
        end
    end

    // Shared-pin stimulus and the ready pattern (wreq low samples per cycle).
    always @(negedge clk) begin
        ad_in = ad_in * 8'd5 + 8'h3B;
        if (!rd_n || !wr_n) begin
            if (wseen < wreq) begin ready = 1'b0; wseen++; end
            else ready = 1'b1;
        end else begin
            ready = 1'b1;
            wseen = 0;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic do_cyc(input logic [1:0] kind, input logic [15:0] addr,
                          input logic [7:0] wd, input int nwait,
                          input logic [15:0] exp_addr, input string tag, input bit poke);
        int n;
        while (busy) @(negedge clk);
        wreq = nwait;
        req_kind = kind; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
        issued++;
        @(negedge clk);
        req_valid = 1'b0;
        chk({addr_hi, ad_out} == exp_addr, tag, {addr_hi, ad_out}, exp_addr);
        n = 0;
        @(negedge clk);
        while (busy) begin
            if (!rd_n || !wr_n) n++;
            if (poke && n == 1) begin
                req_kind = 2'b10; req_addr = 16'hDEAD; req_valid = 1'b1;
            end else req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(n == 2 + nwait, "R6 strobe length", n, 2 + nwait);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!ale && rd_n && wr_n && !ad_oe && !busy, "R1 idle after reset",
            {ale, rd_n, wr_n, ad_oe, busy}, 5'b01100);
        do_cyc(2'b00, 16'hBEEF, 8'h00, 0, 16'h0000, "R9 first fetch", 0);
        do_cyc(2'b00, 16'h1111, 8'h00, 1, 16'h0001, "R9 second fetch", 0);
        do_cyc(2'b11, 16'h12F0, 8'h00, 0, 16'h12F0, "R10 branch-fetch", 0);
        do_cyc(2'b00, 16'h0000, 8'h00, 0, 16'h12F1, "R10 fetch after branch", 0);
        do_cyc(2'b01, 16'hA5C3, 8'h00, 0, 16'hA5C3, "R4 read addr", 0);
        do_cyc(2'b01, 16'h5A3C, 8'h00, 3, 16'h5A3C, "R6 read waits", 0);
        do_cyc(2'b10, 16'h3C81, 8'h5A, 0, 16'h3C81, "R5 write addr", 0);
        do_cyc(2'b10, 16'h7E02, 8'hC3, 2, 16'h7E02, "R6 write waits", 0);
        do_cyc(2'b01, 16'h0F0F, 8'h00, 0, 16'h0F0F, "R8 read before write", 0);
        do_cyc(2'b10, 16'hF0F0, 8'h99, 0, 16'hF0F0, "R8 write after read", 0);
        do_cyc(2'b01, 16'h4242, 8'h00, 2, 16'h4242, "R12 read with poke", 1);
        do_cyc(2'b11, 16'hFFFF, 8'h00, 0, 16'hFFFF, "R10 branch to top", 0);
        do_cyc(2'b00, 16'h1234, 8'h00, 0, 16'h0000, "R9 counter wrap", 0);
        repeat (4) @(negedge clk);
        chk(ale_cnt == issued, "R12 strobe count", ale_cnt, issued);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule